// File: doc/BRIEF.md
# Single-Subarray Line Access Sequencer

This block sequences accesses for one DRAM chip in which every 64-byte cache line sits whole inside a single subarray. A requester hands it line-sized read or write requests addressed by bank, subarray and row over a valid/ready handshake. The block posts the row and column together, so one accepted request is the only command it needs. It then waits a fixed activation delay and moves the line over a narrow 8-bit lane as a train of beats. After the last beat it precharges the bank, so no row stays open between accesses.

Each bank runs its own sequencer, and several banks can be activating, waking or precharging at the same time. Only the data lane is shared: banks that are ready for transfer queue on it, and the lowest-numbered bank goes first. A bank left idle for a set number of cycles drops into a low-power state. A new request to it then pays a fixed wake penalty before activation. The cell array is modelled as plain internal storage.

Top module: `ssa_ctrl`

## Requirements
- R1: While reset is held and just after it is released, every bank reports low power (`bank_sleep` all ones), `req_ready` is high, and `rd_valid` and `wd_take` are low.
- R2: A read returns the 64 bytes of the addressed line as 64 consecutive `rd_valid` beats, byte 0 first, with `rd_last` high on the 64th beat only.
- R3: A write pulls exactly 64 bytes, one per cycle in which `wd_take` is high, and stores the byte on `wd_data` at each such cycle as the next byte of the addressed line (byte 0 first). Other lines, including other rows of the same bank, are unaffected.
- R4: For a bank that is awake and idle, the first read beat is visible T_ACT+1 clock edges after the accepting edge (5 with defaults). No further command from the requester is needed.
- R5: A request accepted by a bank in low power clears that bank's `bank_sleep` at the accepting edge and delays its first read beat by T_WAKE more edges (8 edges in all with defaults).
- R6: After the last data beat the bank precharges: `req_ready` for that bank stays low for T_PRE cycles counted from the cycle that shows `rd_last`, then returns high.
- R7: A bank holds at most one request: `req_ready` is low whenever `req_bank` names a bank with an access in progress, and requests to other idle banks are still accepted meanwhile.
- R8: When more than one bank waits for the lane, the lowest-numbered bank transfers first. The cycle after any `rd_last` never shows `rd_valid`.
- R9: A bank that stays idle after precharge sets `bank_sleep` exactly IDLE_LIMIT edges after precharge ends (T_PRE+IDLE_LIMIT cycles after the `rd_last` cycle). It keeps it set until a request to it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed bank can take the request |
| req_write | input | 1 | 1 = write line, 0 = read line |
| req_bank | input | BANK_W | Target bank |
| req_sub | input | SUB_W | Subarray within the bank |
| req_row | input | ROW_W | Row within the subarray |
| wd_data | input | DATA_W | Write byte, taken when wd_take is high |
| wd_take | output | 1 | Lane consumes wd_data at the next edge |
| rd_valid | output | 1 | Read beat present on rd_data |
| rd_data | output | DATA_W | Read beat |
| rd_last | output | 1 | Final beat of a line |
| bank_sleep | output | NUM_BANKS | Per-bank low-power indication |

## Verification
The bench builds the block with its default parameters: four banks of two subarrays by two rows, T_ACT 4, T_PRE 3, T_WAKE 3 and IDLE_LIMIT 8. With four banks, three requests can queue behind a streaming bank at once, which exposes lane priority. Because the idle limit is short, a bank sleeps between directed tests, so both the awake and the wake-penalty latencies can be measured against fixed edge counts. Two rows per subarray let the vector table put different lines in the same bank to show writes do not disturb each other.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

  typedef enum logic [2:0] {
    BK_SLEEP = 3'd0,
    BK_IDLE  = 3'd1,
    BK_WAKE  = 3'd2,
    BK_ACT   = 3'd3,
    BK_XFER  = 3'd4,
    BK_PRE   = 3'd5
  } bank_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ssa_bank_fsm.sv
module ssa_bank_fsm
  import ssa_pkg::*;
#(
  parameter int unsigned CMD_W      = 3,
  parameter int unsigned T_ACT      = 4,
  parameter int unsigned T_PRE      = 3,
  parameter int unsigned T_WAKE     = 3,
  parameter int unsigned IDLE_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CMD_W-1:0] start_cmd,
  input  logic             lane_gnt,
  input  logic             lane_done,
  output logic             busy,
  output logic             sleep,
  output logic             lane_req,
  output logic [CMD_W-1:0] cmd
);

  localparam int unsigned CW = $clog2(max3(T_ACT, T_PRE, T_WAKE) + 1);
  localparam int unsigned IW = $clog2(IDLE_LIMIT + 1);

  bank_state_e      state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IW-1:0]    idle_q, idle_d;
  logic [CMD_W-1:0] cmd_q;
  logic             cmd_en;

  assign cmd_en   = start;
  assign busy     = (state_q != BK_IDLE) && (state_q != BK_SLEEP);
  assign sleep    = (state_q == BK_SLEEP);
  assign lane_req = (state_q == BK_ACT) && (cnt_q == '0);
  assign cmd      = cmd_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idle_d  = idle_q;
    unique case (state_q)
      BK_SLEEP: begin
        if (start) begin
          state_d = BK_WAKE;
          cnt_d   = CW'(T_WAKE - 1);
        end
      end
      BK_IDLE: begin
        if (start) begin
          state_d = BK_ACT;
          cnt_d   = CW'(T_ACT - 1);
        end else if (idle_q == IW'(IDLE_LIMIT - 1)) begin
          state_d = BK_SLEEP;
        end else begin
          idle_d = idle_q + 1'b1;
        end
      end
      BK_WAKE: begin
        if (cnt_q == '0) begin
          state_d = BK_ACT;
          cnt_d   = CW'(T_ACT - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      BK_ACT: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (lane_gnt) begin
          state_d = BK_XFER;
        end
      end
      BK_XFER: begin
        if (lane_done) begin
          state_d = BK_PRE;
          cnt_d   = CW'(T_PRE - 1);
        end
      end
      BK_PRE: begin
        if (cnt_q == '0) begin
          state_d = BK_IDLE;
          idle_d  = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = BK_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BK_SLEEP;
      cnt_q   <= '0;
      idle_q  <= '0;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idle_q  <= idle_d;
      if (cmd_en) cmd_q <= start_cmd;
    end
  end

endmodule

// File: rtl/ssa_lane.sv
module ssa_lane #(
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned CMD_W      = 3,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BEATS      = 64,
  parameter int unsigned BEAT_W     = 6,
  parameter int unsigned AW         = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS-1:0]       lane_req,
  input  logic [NUM_BANKS*CMD_W-1:0] cmd_flat,
  output logic [NUM_BANKS-1:0]       lane_gnt,
  output logic [NUM_BANKS-1:0]       lane_done,
  output logic                       st_we,
  output logic [AW-1:0]              st_addr,
  output logic [DATA_W-1:0]          st_wdata,
  input  logic [DATA_W-1:0]          st_rdata,
  input  logic [DATA_W-1:0]          wd_data,
  output logic                       wd_take,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_last
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic              busy_q, busy_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [BANK_W-1:0] owner_q, owner_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic              found;
  logic [BANK_W-1:0] gnt_idx;
  logic [CMD_W-1:0]  gnt_cmd;
  logic              is_wr;
  logic              at_last;
  logic              rd_beat;
  logic              rd_valid_q, rd_last_q;
  logic [DATA_W-1:0] rd_data_q;

  // fixed priority: lowest bank index wins a free lane
  always_comb begin
    lane_gnt = '0;
    found    = 1'b0;
    gnt_idx  = '0;
    gnt_cmd  = '0;
    for (int i = 0; i < int'(NUM_BANKS); i++) begin
      if (!busy_q && lane_req[i] && !found) begin
        lane_gnt[i] = 1'b1;
        found       = 1'b1;
        gnt_idx     = BANK_W'(i);
        gnt_cmd     = cmd_flat[i*CMD_W +: CMD_W];
      end
    end
  end

  assign is_wr   = cmd_q[CMD_W-1];
  assign at_last = busy_q && (beat_q == LAST_BEAT);
  assign rd_beat = busy_q && !is_wr;

  always_comb begin
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      lane_done[b] = at_last && (owner_q == BANK_W'(b));
    end
  end

  always_comb begin
    busy_d  = busy_q;
    beat_d  = beat_q;
    owner_d = owner_q;
    cmd_d   = cmd_q;
    if (busy_q) begin
      if (at_last) busy_d = 1'b0;
      else         beat_d = beat_q + 1'b1;
    end else if (found) begin
      busy_d  = 1'b1;
      beat_d  = '0;
      owner_d = gnt_idx;
      cmd_d   = gnt_cmd;
    end
  end

  assign st_addr  = {owner_q, cmd_q[CMD_W-2:0], beat_q};
  assign st_we    = busy_q && is_wr;
  assign st_wdata = wd_data;
  assign wd_take  = busy_q && is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      beat_q     <= '0;
      owner_q    <= '0;
      cmd_q      <= '0;
      rd_valid_q <= 1'b0;
      rd_last_q  <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      busy_q     <= busy_d;
      beat_q     <= beat_d;
      owner_q    <= owner_d;
      cmd_q      <= cmd_d;
      rd_valid_q <= rd_beat;
      rd_last_q  <= rd_beat && at_last;
      if (rd_beat) rd_data_q <= st_rdata;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_last  = rd_last_q;
  assign rd_data  = rd_data_q;

endmodule

// File: rtl/ssa_store.sv
module ssa_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/ssa_ctrl.sv
module ssa_ctrl #(
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned SUBARRAYS  = 2,
  parameter int unsigned ROWS       = 2,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned T_ACT      = 4,
  parameter int unsigned T_PRE      = 3,
  parameter int unsigned T_WAKE     = 3,
  parameter int unsigned IDLE_LIMIT = 8,
  localparam int unsigned BANK_W    = $clog2(NUM_BANKS),
  localparam int unsigned SUB_W     = $clog2(SUBARRAYS),
  localparam int unsigned ROW_W     = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [SUB_W-1:0]     req_sub,
  input  logic [ROW_W-1:0]     req_row,
  input  logic [DATA_W-1:0]    wd_data,
  output logic                 wd_take,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_last,
  output logic [NUM_BANKS-1:0] bank_sleep
);

  localparam int unsigned CMD_W  = 1 + SUB_W + ROW_W;
  localparam int unsigned BEATS  = (LINE_BYTES * 8) / DATA_W;
  localparam int unsigned BEAT_W = $clog2(BEATS);
  localparam int unsigned AW     = BANK_W + SUB_W + ROW_W + BEAT_W;

  logic [1:0]                 rs_q;
  logic                       rst_sync_n;
  logic                       accept;
  logic [CMD_W-1:0]           req_cmd;
  logic [NUM_BANKS-1:0]       bank_busy;
  logic [NUM_BANKS-1:0]       lane_req;
  logic [NUM_BANKS-1:0]       lane_gnt;
  logic [NUM_BANKS-1:0]       lane_done;
  logic [NUM_BANKS*CMD_W-1:0] cmd_flat;
  logic                       st_we;
  logic [AW-1:0]              st_addr;
  logic [DATA_W-1:0]          st_wdata;
  logic [DATA_W-1:0]          st_rdata;

  // reset asserts at once, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign req_ready = !bank_busy[req_bank];
  assign accept    = req_valid && req_ready;
  assign req_cmd   = {req_write, req_sub, req_row};

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    ssa_bank_fsm #(
      .CMD_W     (CMD_W),
      .T_ACT     (T_ACT),
      .T_PRE     (T_PRE),
      .T_WAKE    (T_WAKE),
      .IDLE_LIMIT(IDLE_LIMIT)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .start    (accept && (req_bank == BANK_W'(b))),
      .start_cmd(req_cmd),
      .lane_gnt (lane_gnt[b]),
      .lane_done(lane_done[b]),
      .busy     (bank_busy[b]),
      .sleep    (bank_sleep[b]),
      .lane_req (lane_req[b]),
      .cmd      (cmd_flat[b*CMD_W +: CMD_W])
    );
  end

  ssa_lane #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .CMD_W    (CMD_W),
    .DATA_W   (DATA_W),
    .BEATS    (BEATS),
    .BEAT_W   (BEAT_W),
    .AW       (AW)
  ) u_lane (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lane_req (lane_req),
    .cmd_flat (cmd_flat),
    .lane_gnt (lane_gnt),
    .lane_done(lane_done),
    .st_we    (st_we),
    .st_addr  (st_addr),
    .st_wdata (st_wdata),
    .st_rdata (st_rdata),
    .wd_data  (wd_data),
    .wd_take  (wd_take),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_last  (rd_last)
  );

  ssa_store #(
    .DATA_W(DATA_W),
    .AW    (AW)
  ) u_store (
    .clk  (clk),
    .we   (st_we),
    .addr (st_addr),
    .wdata(st_wdata),
    .rdata(st_rdata)
  );

endmodule

// File: rtl/ssa_ctrl_chk.sv
module ssa_ctrl_chk #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [BANK_W-1:0]    req_bank,
  input logic                 rd_valid,
  input logic                 rd_last,
  input logic                 wd_take,
  input logic [NUM_BANKS-1:0] bank_sleep,
  input logic [NUM_BANKS-1:0] lane_gnt
);

  logic accept;
  assign accept = req_valid && req_ready;

  assert_gnt_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_gnt));

  assert_last_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> !rd_valid);

  assert_last_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  assert_dir_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wd_take));

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bk
    assert_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (req_bank == BANK_W'(b)) && bank_sleep[b]) |=> !bank_sleep[b]);

    assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_sleep[b] && !(accept && (req_bank == BANK_W'(b)))) |=> bank_sleep[b]);
  end

endmodule

bind ssa_ctrl ssa_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_bank  (req_bank),
  .rd_valid  (rd_valid),
  .rd_last   (rd_last),
  .wd_take   (wd_take),
  .bank_sleep(bank_sleep),
  .lane_gnt  (lane_gnt)
);

// File: tb/sim_ssa_ctrl.sv
module sim_ssa_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int BEATS      = 64;
  localparam int T_ACT      = 4;
  localparam int T_PRE      = 3;
  localparam int T_WAKE     = 3;
  localparam int IDLE_LIMIT = 8;
  localparam int NVEC       = 10;

  // {write, bank[1:0], sub, row, seed[7:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 1'b0, 1'b0, 8'd11},
    {1'b1, 2'd1, 1'b1, 1'b0, 8'd22},
    {1'b1, 2'd2, 1'b0, 1'b1, 8'd33},
    {1'b1, 2'd3, 1'b1, 1'b1, 8'd44},
    {1'b1, 2'd0, 1'b0, 1'b1, 8'd55},
    {1'b0, 2'd1, 1'b1, 1'b0, 8'd0},
    {1'b0, 2'd0, 1'b0, 1'b0, 8'd0},
    {1'b0, 2'd0, 1'b0, 1'b1, 8'd0},
    {1'b0, 2'd3, 1'b1, 1'b1, 8'd0},
    {1'b0, 2'd2, 1'b0, 1'b1, 8'd0}
  };

  logic       clk, rst_n;
  logic       req_valid, req_ready, req_write;
  logic [1:0] req_bank;
  logic [0:0] req_sub, req_row;
  logic [7:0] wd_data, rd_data;
  logic       wd_take, rd_valid, rd_last;
  logic [3:0] bank_sleep;

  ssa_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_sub(req_sub), .req_row(req_row),
    .wd_data(wd_data), .wd_take(wd_take), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .bank_sleep(bank_sleep)
  );

  int total, bad;
  logic [7:0] mdl [1024];
  logic [7:0] rbuf [128];
  int rn, rdone;
  int eq_b [32], eq_s [32], eq_r [32];
  int eq_head, eq_tail;
  logic [7:0] wseed;
  int wcount;
  logic prev_last;

  function automatic logic [7:0] pat(input logic [7:0] s, input int beat);
    return s + 8'(beat * 3);
  endfunction

  function automatic int idx(input int b, input int s, input int r, input int beat);
    return b * 256 + s * 128 + r * 64 + beat;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_exp(input int b, input int s, input int r);
    eq_b[eq_tail] = b; eq_s[eq_tail] = s; eq_r[eq_tail] = r;
    eq_tail++;
  endtask

  // call just after a negedge; returns at the negedge after acceptance
  task automatic send_req(input logic w, input int b, input int s, input int r);
    req_write = w; req_bank = 2'(b); req_sub = 1'(s); req_row = 1'(r);
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_last();
    do @(negedge clk); while (!rd_last);
  endtask

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // write-data driver: present byte for the beat about to be taken
  initial begin
    wd_data = '0;
    forever begin
      @(negedge clk);
      if (wd_take === 1'b1) begin
        wd_data = pat(wseed, wcount);
        wcount++;
      end
    end
  end

  // read monitor: R2 stream content/length, R8 order and gap
  initial begin
    rn = 0; rdone = 0; prev_last = 1'b0;
    forever begin
      @(negedge clk);
      if (prev_last) begin
        total++;
        if (rd_valid === 1'b1) begin
          bad++;
          $display("FAIL R8 beat right after last actual=1 expected=0");
        end
      end
      prev_last = (rd_last === 1'b1);
      if (rd_valid === 1'b1) begin
        if (rn < 128) rbuf[rn] = rd_data;
        rn++;
        if (rd_last === 1'b1) begin
          int mism;
          int fa, fe;
          mism = -1; fa = 0; fe = 0;
          for (int i = 0; i < BEATS && i < rn; i++) begin
            if (mism < 0 && rbuf[i] !== mdl[idx(eq_b[eq_head], eq_s[eq_head], eq_r[eq_head], i)]) begin
              mism = i;
              fa = int'(rbuf[i]);
              fe = int'(mdl[idx(eq_b[eq_head], eq_s[eq_head], eq_r[eq_head], i)]);
            end
          end
          total++;
          if (rn != BEATS) begin
            bad++;
            $display("FAIL R2 stream length actual=%0d expected=%0d", rn, BEATS);
          end else if (mism >= 0) begin
            bad++;
            $display("FAIL R2/R8 bank %0d byte %0d actual=%0d expected=%0d",
                     eq_b[eq_head], mism, fa, fe);
          end
          eq_head++;
          rn = 0;
          rdone++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat, base;
    total = 0; bad = 0; eq_head = 0; eq_tail = 0; wcount = 0; wseed = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_bank = '0; req_sub = '0; req_row = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sleep in reset", int'(bank_sleep), 15);
    chk("R1 ready in reset", int'(req_ready), 1);
    chk("R1 rd_valid in reset", int'(rd_valid), 0);
    chk("R1 wd_take in reset", int'(wd_take), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 sleep after release", int'(bank_sleep), 15);

    // vector table: writes then reads (R2, R3)
    for (int v = 0; v < NVEC; v++) begin
      logic w; int b, s, r; logic [7:0] sd;
      w = VEC[v][12]; b = int'(VEC[v][11:10]); s = int'(VEC[v][9]);
      r = int'(VEC[v][8]); sd = VEC[v][7:0];
      if (w) begin
        wseed = sd; wcount = 0;
        send_req(1'b1, b, s, r);
        for (int t = 0; t < 300 && wcount < BEATS; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R3 bytes pulled per write", wcount, BEATS);
        for (int i = 0; i < BEATS; i++) mdl[idx(b, s, r, i)] = pat(sd, i);
      end else begin
        base = rdone;
        push_exp(b, s, r);
        send_req(1'b0, b, s, r);
        while (rdone == base) @(negedge clk);
      end
    end

    // R6 precharge window, then R4 awake latency
    push_exp(1, 1, 0);
    send_req(1'b0, 1, 1, 0);
    wait_last();
    req_bank = 2'd1;
    #1 chk("R6 ready low k0", int'(req_ready), 0);
    for (int k = 1; k < T_PRE; k++) begin
      @(negedge clk);
      #1 chk("R6 ready low during precharge", int'(req_ready), 0);
    end
    @(negedge clk);
    #1 chk("R6 ready back after precharge", int'(req_ready), 1);
    push_exp(1, 1, 0);
    send_req(1'b0, 1, 1, 0);
    lat = 0;
    for (int k = 1; k <= 30 && lat == 0; k++) begin
      @(negedge clk);
      if (rd_valid === 1'b1) lat = k;
    end
    chk("R4 awake first-beat edges", lat, T_ACT + 1);

    // R9 idle power-down timing
    wait_last();
    for (int k = 1; k < T_PRE + IDLE_LIMIT; k++) @(negedge clk);
    chk("R9 awake one edge before limit", int'(bank_sleep[1]), 0);
    @(negedge clk);
    chk("R9 asleep at limit", int'(bank_sleep[1]), 1);
    repeat (5) @(negedge clk);
    chk("R9 stays asleep while untouched", int'(bank_sleep[1]), 1);

    // R5 wake penalty
    push_exp(1, 1, 0);
    send_req(1'b0, 1, 1, 0);
    chk("R5 sleep cleared on accept", int'(bank_sleep[1]), 0);
    lat = 0;
    for (int k = 1; k <= 30 && lat == 0; k++) begin
      @(negedge clk);
      if (rd_valid === 1'b1) lat = k;
    end
    chk("R5 asleep first-beat edges", lat, T_WAKE + T_ACT + 1);
    wait_last();
    repeat (T_PRE + 1) @(negedge clk);

    // R7 / R8: queue two banks behind a streaming one
    base = rdone;
    push_exp(1, 1, 0);
    push_exp(2, 0, 1);
    push_exp(3, 1, 1);
    send_req(1'b0, 1, 1, 0);
    req_bank = 2'd1;
    #1 chk("R7 busy bank not ready", int'(req_ready), 0);
    req_bank = 2'd3;
    #1 chk("R7 other bank ready", int'(req_ready), 1);
    @(negedge clk);
    send_req(1'b0, 3, 1, 1);
    send_req(1'b0, 2, 0, 1);
    for (int t = 0; t < 600 && rdone < base + 3; t++) @(negedge clk);
    chk("R8 queued streams completed", rdone - base, 3);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule